// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Coprocessor

This block performs the four integer multiply and divide operations of a 32-bit processor: signed and unsigned multiply, and signed and unsigned divide. It uses an iterative datapath and places the results in a HI/LO register pair. The pipeline raises `start` for one cycle with an operation code and two operands. The unit captures them, goes busy, and some cycles later raises `ready` with the results held on `hi` and `lo`. Those results stay unchanged until the next accepted start.

Multiply retires two multiplier bits per cycle. Unsigned multiply picks one of the multiples 0, 1, 2 or 3 of the multiplicand, where the triple is computed once at load. Signed multiply uses radix-4 Booth digits in the range -2..+2 over the sign-extended multiplicand. Divide is a restoring divider that retires one quotient bit per cycle. Signed divide first reduces both operands to magnitudes, then runs the same unsigned divider, and applies the signs to the quotient and remainder at the end.

The operands are first captured into input registers. The arithmetic starts one cycle later, so no forwarded operand path reaches the datapath directly.

Top module: `muldiv_unit`

## Requirements
- R1: The `op` encoding is 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide and 2'b11 unsigned divide. `op`, `opa` and `opb` are captured at the rising edge where `start` is high and the unit is neither busy nor in its preparation cycle.
- R2: After reset, `busy`, `ready`, `hi` and `lo` are all 0. From the edge after an accepted start, `busy` is 1 and `ready` is 0. `ready` and `busy` are never high together, and `ready` rises in the same cycle that `busy` falls.
- R3: A `start` pulse while the unit is busy is ignored: the results are those of the first operands and the completion time is unchanged. While idle, `hi` and `lo` hold their values.
- R4: Unsigned multiply leaves the 64-bit unsigned product in {hi, lo}.
- R5: Signed multiply leaves the 64-bit two's-complement product in {hi, lo}.
- R6: Unsigned divide by a nonzero divisor leaves the quotient in `lo` and the remainder in `hi`.
- R7: Signed divide truncates the quotient toward zero. The quotient is negative exactly when the operand signs differ and it is nonzero, and the remainder takes the sign of the dividend.
- R8: Divide by zero raises no trap and `ready` still rises. Unsigned: lo = 32'hFFFF_FFFF and hi = dividend. Signed: hi = dividend, and lo = 1 if the dividend is negative, otherwise 32'hFFFF_FFFF.
- R9: A signed divide of 32'h8000_0000 by 32'hFFFF_FFFF gives lo = 32'h8000_0000 and hi = 0.
- R10: Counting the accepting edge as the first, `ready` is high after rising edge W/2+3 for multiply (19) and after edge W+3 for divide (35).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | Operation code (see R1) |
| opa | input | 32 | Multiplicand / dividend |
| opb | input | 32 | Multiplier / divisor |
| busy | output | 1 | Operation in progress |
| ready | output | 1 | Results in hi/lo are valid |
| hi | output | 32 | Product upper half or remainder |
| lo | output | 32 | Product lower half or quotient |

## Verification
A bad Booth digit decode or a bad multiple selection shows up only in the final {hi, lo} value, W/2+3 edges after the start. Random operands that mix extremes (0, -1, the most negative value, small values) expose it within a few operations. An error in the remainder compare or the shift of the divider corrupts both `hi` and `lo` at completion, W+3 edges after the start. A wrong sign fix shows up only when the operand signs differ, so the directed cases pair every sign combination. Handshake errors, such as a start taken while busy or `ready` overlapping `busy`, show up at the ports within a cycle and are checked both by the latency count and by the results of the disturbed operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2
  } md_state_e;
endpackage

// File: rtl/mul_radix4.sv
module mul_radix4 #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           sgn,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplr,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int ITER = W / 2;
  localparam int CW   = $clog2(ITER + 1);
  localparam int PW   = 2 * W;

  logic [PW-1:0] acc, m1, m3, addend;
  logic [W-1:0]  mr;
  logic          prev, run, sgn_q;
  logic [CW-1:0] cnt;

  // Digit selection: plain radix-4 multiples or Booth-recoded digits
  always_comb begin
    addend = '0;
    if (sgn_q) begin
      case ({mr[1:0], prev})
        3'b001, 3'b010: addend = m1;
        3'b011:         addend = m1 << 1;
        3'b100:         addend = -(m1 << 1);
        3'b101, 3'b110: addend = -m1;
        default:        addend = '0;
      endcase
    end else begin
      case (mr[1:0])
        2'b01:   addend = m1;
        2'b10:   addend = m1 << 1;
        2'b11:   addend = m3;
        default: addend = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0; m1 <= '0; m3 <= '0; mr <= '0;
      prev <= 1'b0; run <= 1'b0; done <= 1'b0; sgn_q <= 1'b0; cnt <= '0;
    end else if (load) begin
      acc   <= '0;
      m1    <= sgn ? {{W{mcand[W-1]}}, mcand} : {{W{1'b0}}, mcand};
      m3    <= sgn ? ({{W{mcand[W-1]}}, mcand} + {{(W-1){mcand[W-1]}}, mcand, 1'b0})
                   : ({{W{1'b0}}, mcand} + {{(W-1){1'b0}}, mcand, 1'b0});
      mr    <= mplr;
      prev  <= 1'b0;
      sgn_q <= sgn;
      cnt   <= '0;
      run   <= 1'b1;
      done  <= 1'b0;
    end else if (run) begin
      acc  <= acc + addend;
      m1   <= m1 << 2;
      m3   <= m3 << 2;
      prev <= mr[1];
      mr   <= mr >> 2;
      cnt  <= cnt + 1'b1;
      if (cnt == CW'(ITER - 1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign prod = acc;

  AST_MUL_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CW'(ITER))); // R10
  AST_MUL_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
endmodule

// File: rtl/div_restoring.sv
module div_restoring #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  dvs;
  logic [W:0]    shifted, diff;
  logic          ge, run;
  logic [CW-1:0] cnt;

  assign shifted = {rem, quo[W-1]};
  assign diff    = shifted - {1'b0, dvs};
  // Remainder stays below the divisor, so the top bit of the difference is the borrow
  assign ge      = ~diff[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      dvs <= '0; quo <= '0; rem <= '0; run <= 1'b0; done <= 1'b0; cnt <= '0;
    end else if (load) begin
      dvs  <= divisor;
      quo  <= dividend;
      rem  <= '0;
      cnt  <= '0;
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      rem <= ge ? diff[W-1:0] : shifted[W-1:0];
      quo <= {quo[W-2:0], ge};
      cnt <= cnt + 1'b1;
      if (cnt == CW'(W - 1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> ((dvs == '0) || (rem < dvs))); // R6
  AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CW'(W))); // R10
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         ready,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  md_state_e     st;
  md_op_e        op_q;
  logic [W-1:0]  a_q, b_q;
  logic          is_div, is_sgn, a_neg, b_neg;
  logic [W-1:0]  a_mag, b_mag;
  logic          mul_load, div_load, mul_done, div_done, core_done;
  logic [2*W-1:0] prod;
  logic [W-1:0]  quo, rem, q_fix, r_fix;

  assign is_div = op_q[1];
  assign is_sgn = ~op_q[0];
  assign a_neg  = is_sgn & a_q[W-1];
  assign b_neg  = is_sgn & b_q[W-1];
  assign a_mag  = a_neg ? -a_q : a_q;
  assign b_mag  = b_neg ? -b_q : b_q;

  assign mul_load = (st == ST_PREP) & ~is_div;
  assign div_load = (st == ST_PREP) & is_div;

  mul_radix4 #(.W(W)) mul_i (
    .clk(clk), .rst(rst), .load(mul_load), .sgn(is_sgn),
    .mcand(a_q), .mplr(b_q), .done(mul_done), .prod(prod)
  );

  div_restoring #(.W(W)) div_i (
    .clk(clk), .rst(rst), .load(div_load),
    .dividend(a_mag), .divisor(b_mag), .done(div_done), .quo(quo), .rem(rem)
  );

  assign core_done = is_div ? div_done : mul_done;
  assign q_fix     = (a_neg ^ b_neg) ? -quo : quo;
  assign r_fix     = a_neg ? -rem : rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; op_q <= OP_MULS; a_q <= '0; b_q <= '0;
      busy <= 1'b0; ready <= 1'b0; hi <= '0; lo <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q  <= md_op_e'(op);
          a_q   <= opa;
          b_q   <= opb;
          busy  <= 1'b1;
          ready <= 1'b0;
          st    <= ST_PREP;
        end
        ST_PREP: st <= ST_RUN;
        ST_RUN: if (core_done) begin
          if (is_div) begin
            hi <= r_fix;
            lo <= q_fix;
          end else begin
            hi <= prod[2*W-1:W];
            lo <= prod[W-1:0];
          end
          busy  <= 1'b0;
          ready <= 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ready && busy)); // R2
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && start) |=> (busy && !ready)); // R2
  AST_READY_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $fell(busy)); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(a_q) && $stable(b_q) && $stable(op_q))); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(hi) && $stable(lo))); // R3
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, ready;
  logic [31:0] hi, lo;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  muldiv_unit #(.W(32)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .ready(ready), .hi(hi), .lo(lo)
  );

  function automatic logic [63:0] ref_res(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      2'b00: return 64'(sa * sb);
      2'b01: return {32'd0, a} * {32'd0, b};
      2'b10: begin
        if (b == 32'd0) return {a, (a[31] ? 32'd1 : 32'hFFFF_FFFF)};
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {32'd0, 32'h8000_0000};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 32'd0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    if (o[1] && b == 32'd0) return "R8";
    if (o == 2'b10 && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R9";
    case (o)
      2'b00: return "R5";
      2'b01: return "R4";
      2'b10: return "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'd0;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return $urandom % 16;
      4: return -($urandom % 16);
      default: return $urandom;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Runs one operation; optionally pulses start mid-operation with other operands
  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b, input bit disturb);
    int lat;
    int exp_lat;
    logic [63:0] exp;
    exp = ref_res(o, a, b);
    exp_lat = o[1] ? 35 : 19;
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; opa = ~a; opb = ~b; op = ~o;
    lat = 1;
    check(busy && !ready, "R2", {62'd0, busy, ready}, 64'd2);
    while (!ready && lat < 200) begin
      if (disturb && lat == 5) begin start = 1'b1; opa = 32'h1234_5678; opb = 32'd3; op = ~o; end
      if (disturb && lat == 6) start = 1'b0;
      @(negedge clk);
      lat++;
    end
    if (!ready) begin
      bad++; total++;
      $display("FAIL R10 ready never rose got=%0d expected=%0d", lat, exp_lat);
    end else begin
      check(lat == exp_lat && !busy, disturb ? "R3" : "R10", 64'(lat), 64'(exp_lat));
    end
    check({hi, lo} == exp, disturb ? "R3" : tag_of(o, a, b), {hi, lo}, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !ready && hi == 0 && lo == 0, "R2", {hi, lo}, 64'd0);

    // Directed corner cases
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R4
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0); // R5
    run_op(2'b00, 32'hFFFF_FFFF, 32'd7, 1'b0);         // R5
    run_op(2'b11, 32'd100, 32'd7, 1'b0);               // R6
    run_op(2'b10, -32'sd7, 32'd2, 1'b0);               // R7
    run_op(2'b10, 32'd7, -32'sd2, 1'b0);               // R7
    run_op(2'b10, -32'sd7, -32'sd2, 1'b0);             // R7
    run_op(2'b11, 32'hDEAD_BEEF, 32'd0, 1'b0);         // R8
    run_op(2'b10, -32'sd9, 32'd0, 1'b0);               // R8
    run_op(2'b10, 32'd9, 32'd0, 1'b0);                 // R8
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R9
    run_op(2'b00, 32'd12345, -32'sd321, 1'b1);         // R3
    run_op(2'b10, -32'sd1000, 32'd33, 1'b1);           // R3

    // Idle hold: results unchanged while idle (R3), start encoding (R1)
    repeat (5) @(negedge clk);
    check({hi, lo} == ref_res(2'b10, -32'sd1000, 32'd33), "R3", {hi, lo}, ref_res(2'b10, -32'sd1000, 32'd33));

    for (int i = 0; i < 1200; i++) begin
      logic [1:0] o;
      o = 2'($urandom % 4);
      run_op(o, pick(), pick(), 1'b0); // R1
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule